// File: doc/BRIEF.md
# Phase-Aligned Dual-Output Clock Divider

This block turns one input clock into two divided clocks. The first output divides by 2 or 4. The second output divides by 4, 5 or 6. Both outputs are built from counters that advance on the same rising edges and restart from one shared phase counter. Rising edges that the two outputs have in common therefore land on the same input clock edge.

A single run enable is captured on the falling edge of the input clock. It starts or stops both dividers at once. A change of enable therefore reaches the dividers only while the input clock is low, and no clock pulse seen by the dividers is ever shortened. While stopped, the counters keep their phase and both outputs sit low. An asynchronous, active-high reset puts every counter into one known phase. The end of reset is taken on a falling edge, so several copies of the block that share a clock and a reset start in step. A new divide selection is taken only when the shared phase counter wraps, so no output period is ever cut short.

Top module: `clkdiv_aligned`

## Requirements
- R1: `div_a_sel` selects the divisor of `clk_a`: 0 gives divide-by-2 and 1 gives divide-by-4. The output is high for the first half of each period, counted in input clock rising edges.
- R2: `div_b_sel` selects the divisor of `clk_b`: 2'b00 gives divide-by-4, 2'b01 gives divide-by-5, 2'b10 gives divide-by-6, and the reserved code 2'b11 also gives divide-by-6. Divide-by-5 is high for 2 input cycles and low for 3. The even divisors are high for exactly half the period.
- R3: The first enabled rising edge after reset is the rising edge that follows the first falling edge after reset release. On that edge both outputs go high together. After that, both outputs rise together at the start of every shared phase period, which is the least common multiple of all supported divisors (60 enabled edges with the default divisors).
- R4: `run_en` is sampled on the falling edge of `clk_in`. A rising edge that follows a low sample drives both outputs low and does not advance any counter.
- R5: After the block is enabled again, counting resumes from the frozen phase. The output pattern continues as if the disabled edges had never happened.
- R6: While `rst` is high, both outputs are low, independent of the clock.
- R7: A new value on a select input is taken only on an enabled rising edge at which the shared phase counter wraps: the first enabled edge after reset and every 60th enabled edge after it. Until then, both outputs keep their current divisors.
- R8: If `run_en` is low when reset ends, both outputs stay low until an enable is sampled. The first enabled rising edge then drives both outputs high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Asynchronous active-high reset; its release is taken on a falling edge |
| run_en | input | 1 | Shared run enable, sampled on the falling edge of `clk_in` |
| div_a_sel | input | 1 | Divisor select for output A (0: /2, 1: /4) |
| div_b_sel | input | 2 | Divisor select for output B (00: /4, 01: /5, 10 and 11: /6) |
| clk_a | output | 1 | Divided clock A |
| clk_b | output | 1 | Divided clock B |

## Verification
The bound checker tests these rules on every clock edge:
- Both outputs are low during reset.
- Both outputs go low on the edge after a low enable sample.
- The counters freeze while disabled.
- Both outputs rise together at each wrap of the shared phase counter.
- The latched divisors change only on a wrap edge.

Only the bench's scenarios can show the following:
- The exact output waveforms for every pair of select codes, including the reserved code and the 2-high/3-low shape of divide-by-5.
- That counting picks up from the frozen phase after a pause.
- That a select change made mid-period takes effect exactly 60 enabled edges after reset.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

   function automatic int gcd_f(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int lcm_f(input int a, input int b);
      return (a / gcd_f(a, b)) * b;
   endfunction

   function automatic int max_f(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cdiv_run_gate.sv
// Captures the run enable on the falling edge; reset clears it at once,
// so the end of reset is seen by the dividers only after a falling edge.
module cdiv_run_gate (
   input  logic clk,
   input  logic rst,
   input  logic en_in,
   output logic en_q
);
   always_ff @(negedge clk or posedge rst) begin
      if (rst) en_q <= 1'b0;
      else     en_q <= en_in;
   end
endmodule

// File: rtl/cdiv_phase_master.sv
// Shared phase counter. Its wrap restarts every bank and latches selects.
module cdiv_phase_master #(
   parameter int MOD = 60
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic wrap
);
   localparam int PW = (MOD > 1) ? $clog2(MOD) : 1;
   localparam logic [PW-1:0] LAST = PW'(MOD - 1);

   generate
      if (MOD < 2) begin : g_bad_mod
         $error("cdiv_phase_master: MOD must be at least 2");
      end
   endgenerate

   logic [PW-1:0] phase;

   assign wrap = (phase == LAST);

   // Reset to the last phase so that the first enabled edge wraps.
   always_ff @(posedge clk or posedge rst) begin
      if (rst)      phase <= LAST;
      else if (adv) phase <= wrap ? '0 : phase + PW'(1);
   end
endmodule

// File: rtl/cdiv_bank.sv
// One divider output with four selectable divisors.
module cdiv_bank #(
   parameter int D0 = 4,
   parameter int D1 = 5,
   parameter int D2 = 6,
   parameter int D3 = 6,
   parameter int DW = 3
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       adv,
   input  logic       wrap,
   input  logic [1:0] sel,
   output logic       clk_out
);
   generate
      if (D0 < 2 || D1 < 2 || D2 < 2 || D3 < 2) begin : g_bad_div
         $error("cdiv_bank: every divisor must be at least 2");
      end
      if ((1 << DW) <= cdiv_pkg::max_f(cdiv_pkg::max_f(D0, D1), cdiv_pkg::max_f(D2, D3))) begin : g_bad_dw
         $error("cdiv_bank: DW too narrow for the divisors");
      end
   endgenerate

   logic [DW-1:0] div_sel;
   logic [DW-1:0] div_q;
   logic [DW-1:0] cnt;
   logic [DW-1:0] cnt_nxt;
   logic          hi_nxt;

   always_comb begin
      unique case (sel)
         2'd0:    div_sel = DW'(D0);
         2'd1:    div_sel = DW'(D1);
         2'd2:    div_sel = DW'(D2);
         default: div_sel = DW'(D3);
      endcase
   end

   // Count 0 is always high, so the divisor that is active at a wrap does
   // not change the output of that edge.
   always_comb begin
      if (wrap || cnt == div_q - DW'(1)) cnt_nxt = '0;
      else                               cnt_nxt = cnt + DW'(1);
      hi_nxt = (cnt_nxt < (div_q >> 1));
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt     <= '0;
         div_q   <= DW'(D0);
         clk_out <= 1'b0;
      end else if (adv) begin
         cnt     <= cnt_nxt;
         clk_out <= hi_nxt;
         if (wrap) div_q <= div_sel;
      end else begin
         clk_out <= 1'b0;
      end
   end
endmodule

// File: rtl/clkdiv_aligned.sv
module clkdiv_aligned #(
   parameter int A_DIV_LO = 2,
   parameter int A_DIV_HI = 4,
   parameter int B_DIV_0  = 4,
   parameter int B_DIV_1  = 5,
   parameter int B_DIV_2  = 6
) (
   input  logic       clk_in,
   input  logic       rst,
   input  logic       run_en,
   input  logic       div_a_sel,
   input  logic [1:0] div_b_sel,
   output logic       clk_a,
   output logic       clk_b
);
   import cdiv_pkg::*;

   localparam int PERIOD = lcm_f(lcm_f(lcm_f(A_DIV_LO, A_DIV_HI), lcm_f(B_DIV_0, B_DIV_1)), B_DIV_2);
   localparam int DW_A   = $clog2(max_f(A_DIV_LO, A_DIV_HI) + 1);
   localparam int DW_B   = $clog2(max_f(max_f(B_DIV_0, B_DIV_1), B_DIV_2) + 1);

   logic en_q;
   logic wrap;

   cdiv_run_gate i_gate (
      .clk   (clk_in),
      .rst   (rst),
      .en_in (run_en),
      .en_q  (en_q)
   );

   cdiv_phase_master #(.MOD(PERIOD)) i_phase (
      .clk  (clk_in),
      .rst  (rst),
      .adv  (en_q),
      .wrap (wrap)
   );

   // Bank A has two divisors; its upper select codes repeat the high one.
   cdiv_bank #(
      .D0(A_DIV_LO), .D1(A_DIV_HI), .D2(A_DIV_HI), .D3(A_DIV_HI), .DW(DW_A)
   ) i_bank_a (
      .clk     (clk_in),
      .rst     (rst),
      .adv     (en_q),
      .wrap    (wrap),
      .sel     ({1'b0, div_a_sel}),
      .clk_out (clk_a)
   );

   cdiv_bank #(
      .D0(B_DIV_0), .D1(B_DIV_1), .D2(B_DIV_2), .D3(B_DIV_2), .DW(DW_B)
   ) i_bank_b (
      .clk     (clk_in),
      .rst     (rst),
      .adv     (en_q),
      .wrap    (wrap),
      .sel     (div_b_sel),
      .clk_out (clk_b)
   );
endmodule

// File: rtl/clkdiv_aligned_chk.sv
module clkdiv_aligned_chk #(
   parameter int DWA = 3,
   parameter int DWB = 3
) (
   input logic           clk,
   input logic           rst,
   input logic           en_q,
   input logic           wrap,
   input logic           out_a,
   input logic           out_b,
   input logic [DWA-1:0] cnt_a,
   input logic [DWB-1:0] cnt_b,
   input logic [DWA-1:0] div_a,
   input logic [DWB-1:0] div_b
);
   // R6: outputs are low while reset is held
   a_r6_reset_low: assert property (@(posedge clk) rst |-> (!out_a && !out_b));

   // R4: a low enable sample forces both outputs low on the next edge
   a_r4_disabled_low: assert property (@(posedge clk) disable iff (rst)
      !en_q |=> (!out_a && !out_b));

   // R5: counters hold their phase while disabled
   a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
      !en_q |=> ($stable(cnt_a) && $stable(cnt_b)));

   // R3: both outputs rise together at every shared phase wrap
   a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
      (en_q && wrap) |=> (out_a && out_b));

   // R7: latched divisors only change on an enabled wrap edge
   a_r7_sel_hold: assert property (@(posedge clk) disable iff (rst)
      !(en_q && wrap) |=> ($stable(div_a) && $stable(div_b)));
endmodule

bind clkdiv_aligned clkdiv_aligned_chk #(.DWA(DW_A), .DWB(DW_B)) i_chk (
   .clk   (clk_in),
   .rst   (rst),
   .en_q  (en_q),
   .wrap  (wrap),
   .out_a (clk_a),
   .out_b (clk_b),
   .cnt_a (i_bank_a.cnt),
   .cnt_b (i_bank_b.cnt),
   .div_a (i_bank_a.div_q),
   .div_b (i_bank_b.div_q)
);

// File: tb/test_clkdiv_aligned.sv
module test_clkdiv_aligned;
   localparam int CLK_PERIOD = 10;
   localparam int SPAN       = 60;

   logic       clk_in = 1'b0;
   logic       rst = 1'b1;
   logic       run_en = 1'b0;
   logic       div_a_sel = 1'b0;
   logic [1:0] div_b_sel = 2'b00;
   logic       clk_a;
   logic       clk_b;

   int  errors = 0;
   int  checks = 0;
   bit  done = 0;

   clkdiv_aligned i_clkdiv_aligned (
      .clk_in    (clk_in),
      .rst       (rst),
      .run_en    (run_en),
      .div_a_sel (div_a_sel),
      .div_b_sel (div_b_sel),
      .clk_a     (clk_a),
      .clk_b     (clk_b)
   );

   always #(CLK_PERIOD / 2) clk_in = ~clk_in;

   function automatic int a_div(input bit s);
      return s ? 4 : 2;
   endfunction

   function automatic int b_div(input bit [1:0] s);
      case (s)
         2'd0:    return 4;
         2'd1:    return 5;
         default: return 6;
      endcase
   endfunction

   function automatic logic level(input int i, input int d);
      return (((i % SPAN) % d) < (d / 2));
   endfunction

   task automatic chk(input string tag, input logic ea, input logic eb);
      checks++;
      if (clk_a !== ea || clk_b !== eb) begin
         errors++;
         $display("FAIL %s: actual a=%b b=%b expected a=%b b=%b at %0t",
                  tag, clk_a, clk_b, ea, eb, $time);
      end
   endtask

   // Reset, load selects, release; the next posedge is enabled index 0.
   task automatic start(input bit sa, input bit [1:0] sb, input bit en);
      @(posedge clk_in);
      #1 rst = 1'b1;
      div_a_sel = sa;
      div_b_sel = sb;
      run_en = en;
      #1 chk("R6 reset low", 1'b0, 1'b0);
      @(posedge clk_in);
      #1 rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1 R2 R3: every select pair over one full shared period
      for (int sa = 0; sa < 2; sa++) begin
         for (int sb = 0; sb < 4; sb++) begin
            start(sa[0], sb[1:0], 1'b1);
            for (int i = 0; i < SPAN + 4; i++) begin
               @(posedge clk_in);
               #2;
               if (i % SPAN == 0) chk("R3 aligned rise", 1'b1, 1'b1);
               else chk("R1 R2 pattern", level(i, a_div(sa[0])), level(i, b_div(sb[1:0])));
            end
         end
      end

      // R4 R5: pause mid-period with /4 and /5, then resume
      start(1'b1, 2'b01, 1'b1);
      for (int i = 0; i < 7; i++) begin
         @(posedge clk_in);
         #2 chk("R1 R2 before pause", level(i, 4), level(i, 5));
      end
      run_en = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(posedge clk_in);
         #2 chk("R4 disabled low", 1'b0, 1'b0);
      end
      run_en = 1'b1;
      for (int i = 7; i < 31; i++) begin
         @(posedge clk_in);
         #2 chk("R5 resume phase", level(i, 4), level(i, 5));
      end

      // R8: enable low at reset release, then first enabled edge
      start(1'b0, 2'b10, 1'b0);
      for (int k = 0; k < 4; k++) begin
         @(posedge clk_in);
         #2 chk("R8 idle low", 1'b0, 1'b0);
      end
      run_en = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(posedge clk_in);
         #2 chk("R8 first enabled", level(i, 2), level(i, 6));
      end

      // R7: select change mid-period waits for the shared wrap
      start(1'b1, 2'b00, 1'b1);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk_in);
         #2 chk("R7 old select", level(i, 4), level(i, 4));
      end
      div_a_sel = 1'b0;
      div_b_sel = 2'b10;
      for (int i = 4; i < SPAN + 14; i++) begin
         @(posedge clk_in);
         #2;
         if (i < SPAN) chk("R7 select held", level(i, 4), level(i, 4));
         else          chk("R7 select applied", level(i, 2), level(i, 6));
      end

      // R6: reset asserted while running forces outputs low
      start(1'b0, 2'b00, 1'b1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule